// File: doc/BRIEF.md
# Parallel-Word First-Order Pulse-Density Modulator

This block turns a 16-bit unsigned sample into a one-bit pulse-density stream. It computes `WORD_W` consecutive stream bits in each fabric clock cycle and packs them into one word for a high-rate serializer lane. The serializer then sends the bits at a multiple of the fabric clock. The single-step error-feedback loop is unrolled combinationally across the bit slots of a word. The error and feedback state left by the last slot seeds the first slot of the next word, so the packed stream matches a one-bit-per-clock modulator bit for bit.

Each step compares the sample with an error register. The bit is 1 when the sample is greater than or equal to the error. A feedback register then takes full scale (all ones) after a 1 and zero after a 0. The error is updated with the feedback registered one step earlier, minus the sample, in wrapping 16-bit arithmetic. Bit 0 of each word is the earliest bit in time.

The output side is a valid/ready stream. The block presents a word with `word_valid_o` high. The word advances only on a clock edge where `word_ready_i` is high, or where no word is yet valid. While valid is high and ready is low, the word and the modulator state are frozen, so no bit is lost or repeated. The sample is taken on the edge that produces a word and applies to every slot of that word. The enable pin is plain control: while it is low, all state is cleared at once, without waiting for a clock.

Top module: `pdm_word_modulator`

## Requirements
- R1: Within a step, the stream bit is 1 exactly when the sample, taken as unsigned, is greater than or equal to the current error value. From the cleared state, a constant sample of 0x8000 gives a first word of 0xAB when `WORD_W` is 8.
- R2: After each step the feedback becomes 0xFFFF if the step's bit was 1 and 0x0000 if it was 0. The next error is the old error plus the old feedback minus the sample, modulo 2^16.
- R3: Bit i of a word is the i-th bit in time. Consecutive words carry the error and feedback state across their boundary. The concatenated words equal the output of a serial one-bit-per-step modulator fed the same samples.
- R4: While `enable_i` is low, `word_o`, `word_valid_o`, the error and the feedback are zero, and this takes effect immediately without a clock edge. The first word after re-enabling starts from error 0 and feedback 0.
- R5: `word_valid_o` goes high on the first rising clock edge after `enable_i` goes high and stays high while `enable_i` stays high.
- R6: When `word_valid_o` is high and `word_ready_i` is low at a rising edge, `word_o` and the internal state hold, and no stream bit is skipped or repeated.
- R7: A sample of 0xFFFF yields all-ones words. A sample of 0x0000, from the cleared state, yields a first word of 0x03 when `WORD_W` is 8, and all-zero words after that.
- R8: For a constant sample x, the count of ones over a long run of words differs from x·bits/65536 by no more than `WORD_W`.
- R9: The sample is captured on each edge that produces a word and is used for all of that word's slots. A change in `sample_i` while a word is stalled does not alter the stalled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| enable_i | input | 1 | Run enable; low clears all state asynchronously |
| sample_i | input | 16 | Unsigned sample, 0x0000 to 0xFFFF |
| word_ready_i | input | 1 | Downstream accepts the current word |
| word_o | output | WORD_W | Packed stream bits, bit 0 earliest |
| word_valid_o | output | 1 | Word on `word_o` is valid |

## Verification
A wrong error or feedback value corrupts the bit decisions inside the very next word. Because the state carries from word to word, that divergence then continues in every later word instead of healing. The bench therefore compares every accepted word with its own serial model, so a fault shows within one or two words of its cause. Faults that only bias the state appear as a drift in the ones density over a few hundred words. A broken hold shows as a stalled word that changes, or as a shifted stream once the stall ends.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int unsigned PDM_SW = 16;
  typedef logic [PDM_SW-1:0] pdm_val_t;
  localparam pdm_val_t PDM_FULL = '1;
  localparam pdm_val_t PDM_ZERO = '0;

  typedef struct packed {
    pdm_val_t err;
    pdm_val_t fb;
  } pdm_state_t;
endpackage

// File: rtl/pdm_slot.sv
module pdm_slot
  import pdm_pkg::*;
(
  input  pdm_val_t   sample_i,
  input  pdm_state_t st_i,
  output logic       bit_o,
  output pdm_state_t st_o
);
  // decision uses the present error; update uses the feedback held from the prior step
  always_comb begin
    bit_o     = (sample_i >= st_i.err);
    st_o.err  = st_i.err + st_i.fb - sample_i;
    st_o.fb   = bit_o ? PDM_FULL : PDM_ZERO;
  end
endmodule

// File: rtl/pdm_unroll.sv
module pdm_unroll
  import pdm_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  pdm_val_t          sample_i,
  input  pdm_state_t        st_i,
  output logic [WORD_W-1:0] word_o,
  output pdm_state_t        st_o
);
  localparam int unsigned NST = WORD_W + 1;

  pdm_state_t chain [NST];

  assign chain[0] = st_i;

  for (genvar s = 0; s < WORD_W; s++) begin : g_slot
    pdm_slot u_slot (
      .sample_i (sample_i),
      .st_i     (chain[s]),
      .bit_o    (word_o[s]),
      .st_o     (chain[s+1])
    );
  end

  assign st_o = chain[WORD_W];
endmodule

// File: rtl/pdm_state.sv
module pdm_state
  import pdm_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              enable_i,
  input  logic              advance_i,
  input  logic [WORD_W-1:0] next_word_i,
  input  pdm_state_t        next_st_i,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q,
  output pdm_state_t        st_q
);
  always_ff @(posedge clk_i or negedge enable_i) begin
    if (!enable_i) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      st_q    <= '{err: PDM_ZERO, fb: PDM_ZERO};
    end else if (advance_i) begin
      word_q  <= next_word_i;
      valid_q <= 1'b1;
      st_q    <= next_st_i;
    end
  end

  // carried feedback must reflect the latest bit of the held word
  p_fb_follows_last_bit_r2: assert property (@(posedge clk_i) disable iff (!enable_i)
    valid_q |-> (st_q.fb == (word_q[WORD_W-1] ? PDM_FULL : PDM_ZERO)));

  p_valid_sticks_r5: assert property (@(posedge clk_i) disable iff (!enable_i)
    valid_q |=> valid_q);

  p_state_holds_r6: assert property (@(posedge clk_i) disable iff (!enable_i)
    !advance_i |=> ($stable(st_q) && $stable(word_q)));
endmodule

// File: rtl/pdm_word_modulator.sv
module pdm_word_modulator
  import pdm_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              enable_i,
  input  logic [15:0]       sample_i,
  input  logic              word_ready_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  pdm_state_t        st_cur;
  pdm_state_t        st_nxt;
  logic [WORD_W-1:0] word_nxt;
  logic              advance;

  assign advance = !word_valid_o || word_ready_i;

  pdm_unroll #(.WORD_W(WORD_W)) u_unroll (
    .sample_i (sample_i),
    .st_i     (st_cur),
    .word_o   (word_nxt),
    .st_o     (st_nxt)
  );

  pdm_state #(.WORD_W(WORD_W)) u_state (
    .clk_i       (clk_i),
    .enable_i    (enable_i),
    .advance_i   (advance),
    .next_word_i (word_nxt),
    .next_st_i   (st_nxt),
    .word_q      (word_o),
    .valid_q     (word_valid_o),
    .st_q        (st_cur)
  );

  p_full_scale_r7: assert property (@(posedge clk_i) disable iff (!enable_i)
    (advance && (sample_i == 16'hFFFF)) |=> (&word_o));

  p_stall_holds_r6: assert property (@(posedge clk_i) disable iff (!enable_i)
    (word_valid_o && !word_ready_i) |=> ($stable(word_o) && word_valid_o));

  p_first_valid_r5: assert property (@(posedge clk_i) disable iff (!enable_i)
    !word_valid_o |=> word_valid_o);
endmodule

// File: tb/test_pdm_word_modulator.sv
module test_pdm_word_modulator;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         enable_i = 1'b0;
  logic [15:0]  sample_i = '0;
  logic         word_ready_i = 1'b0;
  logic [N-1:0] word_o;
  logic         word_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // serial reference state
  logic [15:0]  m_err = '0;
  logic [15:0]  m_fb = '0;
  logic [N-1:0] e_word = '0;
  logic         e_valid = 1'b0;

  always #4 clk_i = ~clk_i;

  pdm_word_modulator #(.WORD_W(N)) i_pdm_word_modulator (
    .clk_i        (clk_i),
    .enable_i     (enable_i),
    .sample_i     (sample_i),
    .word_ready_i (word_ready_i),
    .word_o       (word_o),
    .word_valid_o (word_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one step at a time, as a serial modulator would
  task automatic model_word(input logic [15:0] x, output logic [N-1:0] w);
    for (int i = 0; i < N; i++) begin
      logic b;
      b = (x >= m_err);
      m_err = m_err + m_fb - x;
      m_fb = b ? 16'hFFFF : 16'h0000;
      w[i] = b;
    end
  endtask

  task automatic cycle(input logic [15:0] x, input logic rdy);
    sample_i = x;
    word_ready_i = rdy;
    @(posedge clk_i);
    if (enable_i && (!e_valid || rdy)) begin
      model_word(x, e_word);
      e_valid = 1'b1;
    end
    @(negedge clk_i);
  endtask

  task automatic check_out(input string tag);
    chk(word_valid_o == e_valid, {tag, " valid"}, word_valid_o, e_valid);
    chk(word_o == e_word, {tag, " word"}, word_o, e_word);
  endtask

  task automatic restart();
    enable_i = 1'b0;
    #1;
    m_err = '0; m_fb = '0; e_word = '0; e_valid = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1;
  endtask

  task automatic density(input logic [15:0] x);
    int ones;
    real expd, diff;
    restart();
    ones = 0;
    for (int k = 0; k < 260; k++) begin
      cycle(x, 1'b1);
      check_out("R3 stream");
      if (k >= 4) ones += $countones(word_o);
    end
    expd = real'(x) * 256.0 * N / 65536.0;
    diff = real'(ones) - expd;
    if (diff < 0.0) diff = -diff;
    chk(diff <= real'(N), "R8 density", ones, int'(expd));
  endtask

  initial begin
    logic [N-1:0] held;
    void'($urandom(32'd24681));
    @(negedge clk_i);
    // R4 reset state
    chk(word_valid_o == 1'b0 && word_o == '0, "R4 cleared at start", word_o, 0);

    // R5 and R1 directed from cleared state
    enable_i = 1'b1;
    cycle(16'h8000, 1'b1);
    chk(word_valid_o == 1'b1, "R5 valid after first edge", word_valid_o, 1);
    chk(word_o == 8'hAB, "R1 first word for 0x8000", word_o, 8'hAB);
    check_out("R3 stream");

    // R7 zero input
    restart();
    cycle(16'h0000, 1'b1);
    chk(word_o == 8'h03, "R7 zero input first word", word_o, 8'h03);
    for (int k = 0; k < 4; k++) begin
      cycle(16'h0000, 1'b1);
      chk(word_o == '0, "R7 zero input later words", word_o, 0);
    end
    // R7 full scale
    for (int k = 0; k < 4; k++) begin
      cycle(16'hFFFF, 1'b1);
      chk(word_o == '1, "R7 full scale", word_o, 8'hFF);
    end
    check_out("R2 state carry");

    // R6 and R9 stall with changing sample
    restart();
    cycle(16'h4321, 1'b1);
    cycle(16'h4321, 1'b1);
    held = word_o;
    for (int k = 0; k < 3; k++) begin
      cycle(16'(k * 16'h3000 + 16'h0111), 1'b0);
      chk(word_o == held, "R6 word held in stall", word_o, held);
      chk(word_o == held, "R9 sample ignored while stalled", word_o, held);
    end
    cycle(16'h4321, 1'b1);
    check_out("R6 resume without loss");

    // R4 asynchronous clear mid-stream
    #1 enable_i = 1'b0;
    #1;
    chk(word_valid_o == 1'b0 && word_o == '0, "R4 async clear", word_o, 0);
    m_err = '0; m_fb = '0; e_word = '0; e_valid = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1;
    cycle(16'h8000, 1'b1);
    chk(word_o == 8'hAB, "R4 fresh state after re-enable", word_o, 8'hAB);

    // R2 R3 R6 R9 random stream
    for (int k = 0; k < 600; k++) begin
      logic [15:0] x;
      logic r;
      x = 16'($urandom);
      if (k % 50 == 0) x = 16'hFFFF;
      if (k % 50 == 25) x = 16'h0000;
      r = ($urandom % 4) != 0;
      cycle(x, r);
      check_out("R2 R3 R6 R9 random");
      if (e_valid) chk(word_valid_o, "R5 stays valid", word_valid_o, 1);
    end

    // R8 long-run density
    density(16'h1234);
    density(16'hC000);
    density(16'h0101);
    density(16'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule